// File: doc/BRIEF.md
# ATAPI PIO Burst Read Controller

This block is the device side of a packet-command read in programmed-I/O mode. A host programs a byte-count limit into two byte-wide registers, leaves feature bit 0 clear, and writes the packet opcode to the command register. The block briefly shows busy, then asks for a 12-byte command packet, which the host writes as six 16-bit words. A READ(10) packet carries a starting block address and a block count. The block hands that request to a block-data source and streams the returned bytes back to the host through the 16-bit data register.

The data moves in bursts. Each burst is no longer than the host limit rounded down to an even value. Each burst opens with an interrupt, the data-request status, and the burst length written back into the byte-count registers. Once the last word has been read, a separate completion interrupt is raised. Reading the main status register drops the interrupt. A mirror status address shows the same bits and leaves the interrupt alone.

Top module: `atapi_pio_ctrl`

## Requirements
- R1: After reset the status reads 0x40 (bit 6 ready only), the interrupt is low, both byte-count registers read 0 and `src_ready` is low.
- R2: Writing 0xA0 to address 7 with feature bit 0 clear gives status 0xC0 (busy, bit 7) in the next cycle. Status then becomes 0x48 (ready plus data request, bit 3) with no interrupt, while the packet is awaited.
- R3: The packet is six words written to address 0, each holding bytes 2i in bits 7:0 and 2i+1 in bits 15:8. Opcode 0x28 sits in byte 0. The big-endian block address is in bytes 2 to 5 and the big-endian block count in bytes 7 and 8. A nonzero count produces one `rd_req` pulse carrying both values.
- R4: The limit is {address 5, address 4} latched at the 0xA0 write, with bit 0 forced to 0. If the result is 0, the limit becomes 65534.
- R5: Each burst length equals the smaller of the remaining bytes and the limit. That length reads back from address 4 (low byte) and address 5 (high byte) while the burst is open.
- R6: Before each burst the interrupt rises with status 0x48, so busy, error (bit 0) and fault (bit 5) are clear.
- R7: Address 0 returns source bytes in order, the earlier byte in bits 7:0. Exactly count × 2048 bytes are taken from the source.
- R8: Reading the last word raises the completion interrupt, and status becomes 0x40.
- R9: A block count of 0 raises the completion interrupt with status 0x40, no `rd_req` pulse and no data burst.
- R10: A read of address 7 clears the interrupt. A read of the mirror at address 2 does not.
- R11: A packet opcode other than 0x28, or feature bit 0 set at the 0xA0 write, aborts the command. Status becomes 0x41, address 1 reads 0x04, the interrupt rises and no data moves.
- R12: Busy and data request are never both set, and `src_ready` is high only while the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data (byte registers use bits 7:0) |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| rd_req | output | 1 | One-cycle request to the block source |
| rd_lba | output | 32 | Starting block address of the request |
| rd_blocks | output | 16 | Block count of the request |
| src_valid | input | 1 | Source byte valid |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Block accepts a source byte |

## Verification
The read path is tried with limits above the block size (one burst), a small even limit (four bursts), an odd limit (uneven final burst), and the smallest limit of 2 (1024 bursts). Limits of 0 and 1 check the substitution to 65534. Random limits and block counts against a stalling source separate correct burst arithmetic and byte order from data that is merely correct in total. A zero block count and the two abort causes (foreign opcode, feature bit 0) show that no data moves and that the error register fills.

// File: rtl/atapi_pio_pkg.sv
// Shared constants and phase type for the packet PIO read controller.
package atapi_pio_pkg;
    typedef enum logic [2:0] {
        PH_IDLE, PH_CMDBSY, PH_PKT, PH_DECODE, PH_BSTART, PH_FETCH, PH_DATA
    } phase_t;

    localparam logic [7:0] OPC_PACKET = 8'hA0;
    localparam logic [7:0] OPC_READ10 = 8'h28;

    localparam logic [2:0] ADR_DATA = 3'd0;
    localparam logic [2:0] ADR_FEAT = 3'd1;   // write feature, read error
    localparam logic [2:0] ADR_ALT  = 3'd2;   // status mirror, no side effect
    localparam logic [2:0] ADR_BCLO = 3'd4;
    localparam logic [2:0] ADR_BCHI = 3'd5;
    localparam logic [2:0] ADR_CMD  = 3'd7;   // write command, read status
endpackage

// File: rtl/atapi_pkt_sink.sv
// Collects the command packet as 16-bit words and decodes the READ(10)
// fields. Assumes WORDS >= 5; words arrive low byte first.
module atapi_pkt_sink #(
    parameter int WORDS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        wr_en,
    input  logic [15:0] wdata,
    output logic        full,
    output logic [7:0]  opcode,
    output logic [31:0] lba,
    output logic [15:0] nblk
);
    localparam int CW = $clog2(WORDS + 1);

    logic [15:0]   words_q [WORDS];
    logic [CW-1:0] cnt_q;
    logic          unused_bytes;

    // Store each written word in its slot and count arrivals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < WORDS; i++) words_q[i] <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (wr_en && !full) begin
            for (int i = 0; i < WORDS; i++)
                if (cnt_q == CW'(i)) words_q[i] <= wdata;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign full   = (cnt_q == CW'(WORDS));
    assign opcode = words_q[0][7:0];
    assign lba    = {words_q[1][7:0], words_q[1][15:8], words_q[2][7:0], words_q[2][15:8]};
    assign nblk   = {words_q[3][15:8], words_q[4][7:0]};
    assign unused_bytes = ^{words_q[0][15:8], words_q[3][7:0], words_q[4][15:8], words_q[WORDS-1]};
endmodule

// File: rtl/atapi_burst_size.sv
// Turns the latched host limit into an even burst limit and picks the
// next burst length. Purely combinational.
module atapi_burst_size #(
    parameter int BC_W  = 16,
    parameter int REM_W = 27
) (
    input  logic [BC_W-1:0]  limit,
    input  logic [REM_W-1:0] remaining,
    output logic [BC_W-1:0]  eff_limit,
    output logic [BC_W-1:0]  burst
);
    localparam logic [BC_W-1:0] MAX_EVEN = {{(BC_W-1){1'b1}}, 1'b0};

    // Clear bit 0; a zero result means the largest even size.
    always_comb begin
        eff_limit = {limit[BC_W-1:1], 1'b0};
        if (eff_limit == '0) eff_limit = MAX_EVEN;
        burst = (remaining < REM_W'(eff_limit)) ? remaining[BC_W-1:0] : eff_limit;
    end
endmodule

// File: rtl/atapi_pio_ctrl.sv
// Device-side controller for a packet read in PIO mode: takes the limit
// and opcode, gathers the packet, requests blocks and streams them in
// bursts. Assumes the host reads data only while data request is shown.
module atapi_pio_ctrl
    import atapi_pio_pkg::*;
#(
    parameter int BLK_LG2 = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq,
    output logic        rd_req,
    output logic [31:0] rd_lba,
    output logic [15:0] rd_blocks,
    input  logic        src_valid,
    input  logic [7:0]  src_data,
    output logic        src_ready
);
    localparam int CNT_W = 16;
    localparam int BC_W  = 16;
    localparam int REM_W = CNT_W + BLK_LG2;

    phase_t           phase_q;
    logic             dma_q, err_q, irq_q, hi_q, first_q, rd_req_q;
    logic [BC_W-1:0]  bc_q, lim_q, left_q, eff_lim, burst;
    logic [REM_W-1:0] rem_q;
    logic [15:0]      word_q, blk_q;
    logic [31:0]      lba_q;
    logic [7:0]       stat_w, pkt_opc;
    logic [31:0]      pkt_lba;
    logic [15:0]      pkt_nblk;
    logic             pkt_full, bsy, drq;

    wire wr_cmd  = reg_wr && reg_addr == ADR_CMD;
    wire rd_stat = reg_rd && reg_addr == ADR_CMD;
    wire rd_data = reg_rd && reg_addr == ADR_DATA;

    atapi_pkt_sink #(.WORDS(6)) u_sink (
        .clk(clk), .rst_n(rst_n), .clear(phase_q == PH_IDLE),
        .wr_en(reg_wr && reg_addr == ADR_DATA && phase_q == PH_PKT),
        .wdata(reg_wdata), .full(pkt_full), .opcode(pkt_opc),
        .lba(pkt_lba), .nblk(pkt_nblk)
    );

    atapi_burst_size #(.BC_W(BC_W), .REM_W(REM_W)) u_size (
        .limit(lim_q), .remaining(rem_q), .eff_limit(eff_lim), .burst(burst)
    );

    // Status byte: busy, ready, fault, data request, error.
    always_comb begin
        bsy    = phase_q inside {PH_CMDBSY, PH_DECODE, PH_BSTART, PH_FETCH};
        drq    = phase_q inside {PH_PKT, PH_DATA};
        stat_w = {bsy, 1'b1, 1'b0, 1'b0, drq, 2'b00, err_q};
    end

    // Read-data multiplexer.
    always_comb begin
        unique case (reg_addr)
            ADR_DATA:         reg_rdata = word_q;
            ADR_FEAT:         reg_rdata = {13'd0, err_q, 2'b00};
            ADR_ALT, ADR_CMD: reg_rdata = {8'd0, stat_w};
            ADR_BCLO:         reg_rdata = {8'd0, bc_q[7:0]};
            ADR_BCHI:         reg_rdata = {8'd0, bc_q[15:8]};
            default:          reg_rdata = '0;
        endcase
    end

    // Command sequencer, burst counting and interrupt (set beats clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE; dma_q <= 1'b0; err_q <= 1'b0; irq_q <= 1'b0;
            hi_q <= 1'b0; first_q <= 1'b0; rd_req_q <= 1'b0;
            bc_q <= '0; lim_q <= '0; left_q <= '0; rem_q <= '0;
            word_q <= '0; blk_q <= '0; lba_q <= '0;
        end else begin
            rd_req_q <= 1'b0;
            if (rd_stat) irq_q <= 1'b0;
            if (reg_wr && reg_addr == ADR_FEAT) dma_q <= reg_wdata[0];
            if (reg_wr && reg_addr == ADR_BCLO) bc_q[7:0] <= reg_wdata[7:0];
            if (reg_wr && reg_addr == ADR_BCHI) bc_q[15:8] <= reg_wdata[7:0];
            unique case (phase_q)
                PH_IDLE: if (wr_cmd && reg_wdata[7:0] == OPC_PACKET) begin
                    lim_q <= bc_q;
                    err_q <= dma_q;
                    if (dma_q) irq_q <= 1'b1;
                    else       phase_q <= PH_CMDBSY;
                end
                PH_CMDBSY: phase_q <= PH_PKT;
                PH_PKT:    if (pkt_full) phase_q <= PH_DECODE;
                PH_DECODE: begin
                    if (pkt_opc != OPC_READ10) begin
                        err_q <= 1'b1; irq_q <= 1'b1; phase_q <= PH_IDLE;
                    end else if (pkt_nblk == '0) begin
                        irq_q <= 1'b1; phase_q <= PH_IDLE;
                    end else begin
                        rd_req_q <= 1'b1; lba_q <= pkt_lba; blk_q <= pkt_nblk;
                        rem_q <= REM_W'(pkt_nblk) << BLK_LG2;
                        phase_q <= PH_BSTART;
                    end
                end
                PH_BSTART: begin
                    left_q <= burst; bc_q <= burst;
                    first_q <= 1'b1; hi_q <= 1'b0; phase_q <= PH_FETCH;
                end
                PH_FETCH: if (src_valid) begin
                    if (!hi_q) word_q <= {8'h00, src_data};
                    else       word_q[15:8] <= src_data;
                    left_q <= left_q - 1'b1;
                    rem_q  <= rem_q - 1'b1;
                    hi_q   <= !hi_q;
                    if (hi_q || left_q == BC_W'(1)) begin
                        phase_q <= PH_DATA; hi_q <= 1'b0; first_q <= 1'b0;
                        if (first_q) irq_q <= 1'b1;
                    end
                end
                PH_DATA: if (rd_data) begin
                    if (left_q != '0)     phase_q <= PH_FETCH;
                    else if (rem_q != '0) phase_q <= PH_BSTART;
                    else begin irq_q <= 1'b1; phase_q <= PH_IDLE; end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign irq       = irq_q;
    assign rd_req    = rd_req_q;
    assign rd_lba    = lba_q;
    assign rd_blocks = blk_q;
    assign src_ready = (phase_q == PH_FETCH);
endmodule

// File: rtl/atapi_pio_chk.sv
// Protocol checker for atapi_pio_ctrl, attached by bind below.
module atapi_pio_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic        reg_rd,
    input logic [2:0]  reg_addr,
    input logic        src_valid,
    input logic        src_ready,
    input logic [7:0]  stat_w,
    input logic [15:0] left_q,
    input logic        err_q
);
    assert_bsy_drq_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_w[7] && stat_w[3]));
    assert_src_when_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> stat_w[7]);
    assert_irq_cleared_by_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_rd && reg_addr == 3'd7));
    assert_irq_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !stat_w[7]);
    assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready) |-> left_q != 16'd0);
    assert_err_no_drq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !stat_w[3]);
endmodule

bind atapi_pio_ctrl atapi_pio_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .src_valid(src_valid), .src_ready(src_ready), .stat_w(stat_w),
    .left_q(left_q), .err_q(err_q)
);

// File: tb/tb_atapi_pio_ctrl.sv
module tb_atapi_pio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq, rd_req, src_ready;
    logic [31:0] rd_lba;
    logic [15:0] rd_blocks;
    logic        src_valid = 1'b0;
    logic [7:0]  src_data;

    int checks = 0, errors = 0, excl_bad = 0, req_cnt = 0;
    bit done = 0;
    logic [31:0] s_lba = 0;
    logic [15:0] s_blk = 0;
    int unsigned s_off = 0;

    always #4 clk = ~clk;

    atapi_pio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .rd_req(rd_req), .rd_lba(rd_lba), .rd_blocks(rd_blocks),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready)
    );

    function automatic logic [7:0] fbyte(logic [31:0] l, int unsigned o);
        return 8'(l * 13 + o + (o >> 8) * 5);
    endfunction

    // Block source model: latches the request, counts accepted bytes.
    always @(posedge clk) begin
        if (rd_req) begin
            s_lba <= rd_lba; s_blk <= rd_blocks; s_off <= 0; req_cnt <= req_cnt + 1;
        end else if (src_valid && src_ready) s_off <= s_off + 1;
    end
    assign src_data = fbyte(s_lba, s_off);
    always @(negedge clk) src_valid <= ($urandom % 4) != 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        if ((a == 3'd2 || a == 3'd7) && d[7] && d[3]) excl_bad++;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq(output bit ok);
        int n = 0;
        while (!irq && n < 5000) begin @(negedge clk); n++; end
        ok = irq;
    endtask

    task automatic poll_drq(output logic [15:0] s);
        int n = 0;
        rd(3'd2, s);
        while (!s[3] && n < 1000) begin rd(3'd2, s); n++; end
    endtask

    task automatic run_cmd(input logic [15:0] lim, input logic [31:0] lba,
                           input logic [15:0] nblk, input bit dma, input logic [7:0] opc);
        logic [15:0] s, d, bc_lo, bc_hi;
        logic [7:0] b [12];
        bit ok;
        int base;
        int unsigned eff, remb, off, bl;
        base = req_cnt;
        wr(3'd4, {8'd0, lim[7:0]}); wr(3'd5, {8'd0, lim[15:8]});
        wr(3'd1, {15'd0, dma});
        wr(3'd7, 16'h00A0);
        if (dma) begin
            rd(3'd2, s); chk(s[7:0] == 8'h41, "R11", "dma abort status", s, 8'h41);
            chk(irq == 1'b1, "R11", "dma abort irq", irq, 1);
            rd(3'd1, d); chk(d == 16'h0004, "R11", "error reg", d, 4);
            rd(3'd7, s);
            return;
        end
        rd(3'd2, s); chk(s[7:0] == 8'hC0, "R2", "busy after packet cmd", s, 8'hC0);
        poll_drq(s); chk(s[7:0] == 8'h48, "R2", "packet request status", s, 8'h48);
        chk(irq == 1'b0, "R2", "no irq for packet request", irq, 0);
        foreach (b[i]) b[i] = 8'h00;
        b[0] = opc; b[2] = lba[31:24]; b[3] = lba[23:16]; b[4] = lba[15:8]; b[5] = lba[7:0];
        b[7] = nblk[15:8]; b[8] = nblk[7:0];
        for (int i = 0; i < 6; i++) wr(3'd0, {b[2*i+1], b[2*i]});
        wait_irq(ok);
        chk(ok, "R8", "irq after packet", irq, 1);
        if (opc != 8'h28) begin
            rd(3'd2, s); chk(s[7:0] == 8'h41, "R11", "opcode abort status", s, 8'h41);
            rd(3'd1, d); chk(d == 16'h0004, "R11", "error reg", d, 4);
            chk(req_cnt == base, "R11", "no source request", req_cnt, base);
            rd(3'd7, s); chk(irq == 1'b0, "R10", "status read clears irq", irq, 0);
            return;
        end
        if (nblk == 16'd0) begin
            chk(req_cnt == base, "R9", "no source request", req_cnt, base);
            rd(3'd7, s); chk(s[7:0] == 8'h40, "R9", "zero-count completion", s, 8'h40);
            return;
        end
        chk(req_cnt == base + 1, "R3", "one request pulse", req_cnt, base + 1);
        chk(s_lba == lba, "R3", "request lba", s_lba, lba);
        chk(s_blk == nblk, "R3", "request count", s_blk, nblk);
        eff = int'(lim) & 32'hFFFE;
        if (eff == 0) eff = 65534;
        remb = int'(nblk) * 2048;
        off = 0;
        while (remb > 0) begin
            int mism = 0;
            logic [15:0] first_act = 0, first_exp = 0;
            bl = (remb < eff) ? remb : eff;
            rd(3'd2, s); chk(s[7:0] == 8'h48, "R6", "burst status", s, 8'h48);
            chk(irq == 1'b1, "R10", "mirror keeps irq", irq, 1);
            rd(3'd4, bc_lo); rd(3'd5, bc_hi);
            chk({bc_hi[7:0], bc_lo[7:0]} == 16'(bl), "R5", "burst byte count",
                {bc_hi[7:0], bc_lo[7:0]}, bl);
            rd(3'd7, s); chk(irq == 1'b0, "R10", "status read clears irq", irq, 0);
            for (int k = 0; k < int'((bl + 1) / 2); k++) begin
                logic [15:0] ex;
                if (k > 0) poll_drq(s);
                rd(3'd0, d);
                ex = {fbyte(lba, off + 1), fbyte(lba, off)};
                if (2 * k + 1 == int'(bl)) ex[15:8] = 8'h00;
                if (d != ex && mism == 0) begin first_act = d; first_exp = ex; end
                if (d != ex) mism++;
                off += 2;
            end
            chk(mism == 0, "R7", "burst data words", first_act, first_exp);
            remb -= bl;
            wait_irq(ok);
            chk(ok, "R6", "irq for next burst or completion", irq, 1);
        end
        rd(3'd2, s); chk(s[7:0] == 8'h40, "R8", "completion status", s, 8'h40);
        chk(s_off == int'(nblk) * 2048, "R7", "bytes taken from source", s_off, int'(nblk) * 2048);
        rd(3'd7, s);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not end actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] s;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd2, s); chk(s[7:0] == 8'h40, "R1", "reset status", s, 8'h40);
        chk(irq == 1'b0, "R1", "reset irq", irq, 0);
        chk(src_ready == 1'b0, "R1", "reset src_ready", src_ready, 0);
        rd(3'd4, s); chk(s == 16'd0, "R1", "reset count low", s, 0);
        rd(3'd5, s); chk(s == 16'd0, "R1", "reset count high", s, 0);
        run_cmd(16'd5120, 32'h0001_2345, 16'd1, 1'b0, 8'h28);
        run_cmd(16'd512,  32'hA1B2_C3D4, 16'd1, 1'b0, 8'h28);
        run_cmd(16'd777,  32'd7,         16'd1, 1'b0, 8'h28); // odd limit R4
        run_cmd(16'd0,    32'd9,         16'd1, 1'b0, 8'h28); // zero limit R4
        run_cmd(16'd1,    32'd11,        16'd2, 1'b0, 8'h28); // limit 1 R4
        run_cmd(16'd2,    32'd3,         16'd1, 1'b0, 8'h28); // smallest burst R5
        run_cmd(16'd4096, 32'd5,         16'd0, 1'b0, 8'h28); // zero blocks R9
        run_cmd(16'd4096, 32'd5,         16'd1, 1'b0, 8'h12); // foreign opcode R11
        run_cmd(16'd4096, 32'd5,         16'd1, 1'b1, 8'h28); // dma bit R11
        run_cmd(16'd3000, 32'd21,        16'd1, 1'b0, 8'h28); // recovers after abort
        for (int r = 0; r < 4; r++)
            run_cmd(16'($urandom_range(3, 6000)), $urandom, 16'($urandom_range(1, 2)), 1'b0, 8'h28);
        chk(excl_bad == 0, "R12", "busy and data request never together", excl_bad, 0);
        finish_run();
    end
endmodule